// File: doc/BRIEF.md
# Dual-Mode Coprocessor Bus Slave

This block lets a coprocessor sit as a slave on a host processor's local bus. It samples a 12-bit word address, an active-low chip select and a read/write line. It decodes the top address bits into one select line per internal execution unit and passes read and write data between the bus and the selected unit. The host bus pad is modelled as separate input, output and output-enable vectors.

A static mode input chooses one of two handshakes. In strobe mode, a cycle opens on a transfer-start strobe and closes with a single active-low acknowledge. In burst mode, each data beat must be qualified by an active-low data-valid input. A burst of four beats can be requested, and wait states are shown on an active-high wait output. The acknowledge and the wait indication share one output pin.

Each unit access is preceded by a fixed number of wait cycles, set by a parameter.

Top module: `cop_bus_slave`

## Requirements
- R1: While reset is asserted and after it, with no transfer open, `unit_sel`=0, `unit_we`=0 and `data_oe`=0. `ack_wait` is 1 when `mode_burst`=0 and 0 when `mode_burst`=1.
- R2: A transfer opens only at a clock edge where the block is idle and both `cs_n`=0 and `ts_n`=0. Any other combination leaves the block idle.
- R3: During a transfer exactly one `unit_sel` bit is high. Its index is `addr[AW-1:AW-2]` as captured at the opening edge (with 4 units), and `unit_addr` carries the captured address.
- R4: With `mode_burst`=0, `ack_wait` stays 1 for WAIT_CYC cycles after the opening edge. It then drops to 0 for exactly one cycle. In that cycle a write raises `unit_we` and a read presents `unit_rdata` on `data_out`.
- R5: With `mode_burst`=0, `dval_n` and `burst_n` have no effect, and every transfer is a single beat.
- R6: With `mode_burst`=1, `ack_wait` is 1 for WAIT_CYC cycles before each beat and 0 once the beat may complete.
- R7: With `mode_burst`=1, a beat completes only in a cycle with `ack_wait`=0 and `dval_n`=0. While `dval_n`=1 the block holds the beat.
- R8: With `mode_burst`=1 and `burst_n`=0 at the opening edge, the transfer moves four beats. `unit_addr[1:0]` advances by one, modulo 4, after each beat. With `burst_n`=1 the transfer moves one beat.
- R9: `data_oe` is 1 only for read transfers while `cs_n`=0. It is raised from the cycle after the opening edge and released in the cycle after the final beat.
- R10: Driving `rst_n` low returns the block to idle at once, without waiting for a clock edge, even in the middle of a transfer.
- R11: In a write beat `unit_wdata` equals `data_in`, and the selected unit stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_burst | input | 1 | 0 = strobe/acknowledge mode, 1 = burst mode |
| cs_n | input | 1 | Chip select, active low |
| ts_n | input | 1 | Transfer start strobe, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| burst_n | input | 1 | Burst request, active low, burst mode only |
| dval_n | input | 1 | Data beat valid, active low, burst mode only |
| addr | input | AW | Word address |
| data_in | input | DW | Write data from the bus pad |
| data_out | output | DW | Read data to the bus pad |
| data_oe | output | 1 | Bus pad output enable |
| ack_wait | output | 1 | Acknowledge (active low, strobe mode) or wait (active high, burst mode) |
| unit_sel | output | NUNITS | One-hot execution unit select |
| unit_addr | output | AW | Address presented to the units |
| unit_we | output | 1 | Write strobe to the selected unit |
| unit_wdata | output | DW | Write data to the units |
| unit_rdata | input | DW | Read data from the selected unit |

## Verification
The bench builds the block with WAIT_CYC=2, four units and four-beat bursts. Two wait cycles make the counter reload between burst beats visible. They also give room to assert reset while a wait is still pending. Four units give every top-address decode value its own select line, and a burst starting at an odd offset within its group of four makes the address wrap inside a single burst.

// File: rtl/cop_bus_slave.sv
`timescale 1ns/1ps
module cop_bus_slave #(
  parameter int AW       = 12,
  parameter int DW       = 32,
  parameter int NUNITS   = 4,
  parameter int WAIT_CYC = 2,
  parameter int BEATS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_burst,
  input  logic              cs_n,
  input  logic              ts_n,
  input  logic              rd_wr,
  input  logic              burst_n,
  input  logic              dval_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     data_in,
  output logic [DW-1:0]     data_out,
  output logic              data_oe,
  output logic              ack_wait,
  output logic [NUNITS-1:0] unit_sel,
  output logic [AW-1:0]     unit_addr,
  output logic              unit_we,
  output logic [DW-1:0]     unit_wdata,
  input  logic [DW-1:0]     unit_rdata
);
  localparam int SW = (NUNITS > 1) ? $clog2(NUNITS) : 1;
  localparam int CW = $clog2(WAIT_CYC + 2);
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic          busy, rw_q, burst_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt;
  logic [BW-1:0] beat;
  logic          start, ready, beat_done, last;

  assign start     = !busy && !cs_n && !ts_n;
  assign ready     = busy && (cnt == '0);
  assign beat_done = ready && (!mode_burst || !dval_n);
  assign last      = !burst_q || (beat == BW'(BEATS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rw_q    <= 1'b0;
      burst_q <= 1'b0;
      addr_q  <= '0;
      cnt     <= '0;
      beat    <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      rw_q    <= rd_wr;
      burst_q <= mode_burst && !burst_n;
      addr_q  <= addr;
      cnt     <= CW'(WAIT_CYC);
      beat    <= '0;
    end else if (busy) begin
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (beat_done) begin
        if (last) begin
          busy <= 1'b0;
        end else begin
          beat              <= beat + 1'b1;
          addr_q[BW-1:0]    <= addr_q[BW-1:0] + 1'b1;
          cnt               <= CW'(WAIT_CYC);
        end
      end
    end
  end

  for (genvar i = 0; i < NUNITS; i++) begin : g_sel
    assign unit_sel[i] = busy && (addr_q[AW-1 -: SW] == SW'(i));
  end

  assign unit_addr  = addr_q;
  assign unit_we    = beat_done && !rw_q;
  assign unit_wdata = data_in;
  assign data_out   = unit_rdata;
  assign data_oe    = busy && rw_q && !cs_n;
  assign ack_wait   = mode_burst ? (busy && !ready) : !ready;
endmodule

module cop_bus_slave_chk #(
  parameter int NUNITS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_burst,
  input logic              cs_n,
  input logic              dval_n,
  input logic              ack_wait,
  input logic              data_oe,
  input logic [NUNITS-1:0] unit_sel,
  input logic              unit_we
);
  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_sel));
  // R3
  sel_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_sel != '0) |=> (unit_sel == '0 || $stable(unit_sel)));
  // R4
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_burst && !ack_wait) |=> (ack_wait || mode_burst));
  // R6
  no_we_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_burst && ack_wait) |-> !unit_we);
  // R7
  we_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_burst && unit_we) |-> !dval_n);
  // R9
  oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !cs_n);
  // R11
  we_has_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_we |-> (unit_sel != '0));
endmodule

bind cop_bus_slave cop_bus_slave_chk #(.NUNITS(NUNITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_burst(mode_burst), .cs_n(cs_n),
  .dval_n(dval_n), .ack_wait(ack_wait), .data_oe(data_oe),
  .unit_sel(unit_sel), .unit_we(unit_we)
);

// File: tb/tb_cop_bus_slave.sv
`timescale 1ns/1ps
module tb_cop_bus_slave;
  localparam int W = 2;
  logic clk = 0, rst_n = 0, mode_burst = 0, cs_n = 1, ts_n = 1, rd_wr = 1;
  logic burst_n = 1, dval_n = 1;
  logic [11:0] addr = '0;
  logic [31:0] data_in = '0, data_out, unit_wdata, unit_rdata;
  logic data_oe, ack_wait, unit_we;
  logic [3:0] unit_sel;
  logic [11:0] unit_addr;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  cop_bus_slave #(.WAIT_CYC(W)) dut (
    .clk(clk), .rst_n(rst_n), .mode_burst(mode_burst), .cs_n(cs_n), .ts_n(ts_n),
    .rd_wr(rd_wr), .burst_n(burst_n), .dval_n(dval_n), .addr(addr),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .ack_wait(ack_wait),
    .unit_sel(unit_sel), .unit_addr(unit_addr), .unit_we(unit_we),
    .unit_wdata(unit_wdata), .unit_rdata(unit_rdata));

  logic [31:0] mem [4][16];
  logic [31:0] exp_mem [4][16];
  initial
    for (int u = 0; u < 4; u++)
      for (int i = 0; i < 16; i++) begin
        mem[u][i] = 32'h5A5A0000 ^ 32'(u * 256 + i);
        exp_mem[u][i] = 32'h5A5A0000 ^ 32'(u * 256 + i);
      end
  assign unit_rdata = mem[unit_addr[11:10]][unit_addr[3:0]];
  always @(posedge clk) if (unit_we) mem[unit_addr[11:10]][unit_addr[3:0]] <= unit_wdata;

  // behavioural reference
  bit m_busy = 0, m_rw = 0, m_burst = 0;
  int m_cnt = 0, m_beat = 0;
  logic [11:0] m_addr = '0;

  function automatic bit m_ready(); return m_busy && m_cnt == 0; endfunction
  function automatic bit m_we();
    return m_ready() && !m_rw && (!mode_burst || !dval_n);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_beat = 0;
    end else if (!m_busy) begin
      if (!cs_n && !ts_n) begin
        m_busy = 1; m_cnt = W; m_beat = 0; m_addr = addr; m_rw = rd_wr;
        m_burst = mode_burst && !burst_n;
      end
    end else if (m_cnt > 0) begin
      m_cnt--;
    end else if (!mode_burst) begin
      if (!m_rw) exp_mem[m_addr[11:10]][m_addr[3:0]] = data_in;
      m_busy = 0;
    end else if (!dval_n) begin
      if (!m_rw) exp_mem[m_addr[11:10]][m_addr[3:0]] = data_in;
      if (!m_burst || m_beat == 3) m_busy = 0;
      else begin
        m_beat++; m_addr = {m_addr[11:2], m_addr[1:0] + 2'd1}; m_cnt = W;
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic exp_ack;
    exp_ack = mode_burst ? (m_busy && !m_ready()) : !m_ready();
    chk(mode_burst ? "R6 ack_wait" : "R4 ack_wait", 32'(ack_wait), 32'(exp_ack));
    chk("R3 unit_sel", 32'(unit_sel), m_busy ? (32'd1 << m_addr[11:10]) : 32'd0);
    chk(mode_burst ? "R7 unit_we" : "R5 unit_we", 32'(unit_we), 32'(m_we()));
    chk("R9 data_oe", 32'(data_oe), 32'(m_busy && m_rw && !cs_n));
    if (m_busy) chk("R8 unit_addr", 32'(unit_addr), 32'(m_addr));
    if (m_we()) chk("R11 unit_wdata", unit_wdata, data_in);
    if (m_ready() && m_rw && (!mode_burst || !dval_n))
      chk("R4 data_out", data_out, exp_mem[m_addr[11:10]][m_addr[3:0]]);
  end

  logic [31:0] seed = 32'h1234_0000;
  task automatic xfer(input logic rw, input logic [11:0] a, input logic bst,
                      input int stall, output int nb);
    int guard;
    nb = 0; guard = 0;
    @(posedge clk); #1;
    cs_n = 0; ts_n = 0; rd_wr = rw; addr = a; burst_n = !bst; dval_n = 1;
    @(posedge clk); #1;
    ts_n = 1;
    while (m_busy && guard < 100) begin
      dval_n = (stall > 0) && (guard % stall == 0);
      data_in = seed ^ 32'(guard * 7919) ^ {20'h0, a};
      @(negedge clk);
      if (!mode_burst && !ack_wait) nb++;
      if (mode_burst && !ack_wait && !dval_n && unit_sel != 0) nb++;
      @(posedge clk); #1;
      guard++;
    end
    if (guard >= 100) chk("R2 transfer hung", 32'(guard), 32'd0);
    cs_n = 1; dval_n = 1;
    seed = seed + 32'h0001_0001;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_err++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int nb;
    #12;
    // R1 reset state, strobe mode
    chk("R1 ack_wait", 32'(ack_wait), 32'd1);
    chk("R1 unit_sel", 32'(unit_sel), 32'd0);
    chk("R1 data_oe", 32'(data_oe), 32'd0);
    chk("R1 unit_we", 32'(unit_we), 32'd0);
    @(posedge clk); #1 rst_n = 1;
    // R2 no start without both strobes
    cs_n = 0; ts_n = 1; repeat (3) @(posedge clk); #1;
    cs_n = 1; ts_n = 0; repeat (3) @(posedge clk); #1;
    ts_n = 1;
    @(negedge clk) chk("R2 stays idle", 32'(unit_sel), 32'd0);
    // strobe mode transfers
    xfer(0, 12'h005, 0, 0, nb); chk("R4 single ack", 32'(nb), 32'd1);
    xfer(0, 12'h80A, 1, 2, nb); chk("R5 burst ignored", 32'(nb), 32'd1);
    xfer(1, 12'h005, 0, 0, nb); chk("R4 read ack", 32'(nb), 32'd1);
    xfer(1, 12'h80A, 1, 3, nb); chk("R5 read single", 32'(nb), 32'd1);
    xfer(1, 12'hC00, 0, 0, nb);
    // burst mode
    @(posedge clk); #1 mode_burst = 1;
    @(negedge clk) chk("R1 idle wait low", 32'(ack_wait), 32'd0);
    xfer(0, 12'h402, 1, 0, nb); chk("R8 burst write beats", 32'(nb), 32'd4);
    xfer(1, 12'h402, 1, 2, nb); chk("R8 burst read beats", 32'(nb), 32'd4);
    xfer(0, 12'hC07, 0, 3, nb); chk("R8 single write beat", 32'(nb), 32'd1);
    xfer(1, 12'hC07, 0, 2, nb); chk("R7 single read beat", 32'(nb), 32'd1);
    xfer(1, 12'h403, 1, 0, nb); chk("R8 wrap read beats", 32'(nb), 32'd4);
    // R10 reset in mid transfer
    @(posedge clk); #1;
    cs_n = 0; ts_n = 0; rd_wr = 1; addr = 12'h801; burst_n = 0;
    @(posedge clk); #1 ts_n = 1;
    @(posedge clk); #3 rst_n = 0;
    #1;
    chk("R10 unit_sel", 32'(unit_sel), 32'd0);
    chk("R10 data_oe", 32'(data_oe), 32'd0);
    chk("R10 ack_wait", 32'(ack_wait), 32'd0);
    cs_n = 1;
    @(posedge clk); #1 rst_n = 1;
    // back to strobe mode, read what burst mode wrote
    @(posedge clk); #1 mode_burst = 0;
    xfer(1, 12'h400, 0, 0, nb); chk("R11 readback", 32'(nb), 32'd1);
    xfer(1, 12'h401, 0, 0, nb);
    xfer(1, 12'hC07, 0, 0, nb);
    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule